// File: doc/BRIEF.md
# Panel Power Sequencer

This block brings a flat panel up and down in a fixed order. Turning on asserts the display controller enable first and keeps panel power low. A settling window is then counted on a millisecond tick input so that the contrast voltage can stabilise. After that, an optional board-specific handshake step runs, and only then is panel power switched on. Turning off runs the same steps in reverse. Panel power is dropped first. The same settling window is counted, the handshake step runs again, and the controller enable is cleared last.

A single start request and a single stop request drive the sequencer. The controller-enable output goes to the timing generator. The panel-power output goes to the supply switch. The busy output is high for the whole of each transition, and any request that arrives in that time is dropped. The handshake step is a compile-time option. When it is left out, the final transition follows directly on the end of the settling window.

Top module: `pps_top`

## Requirements
- R1: In the idle-off state, a start_req sampled high makes ctrl_en high on the next cycle while panel_pwr stays low and busy goes high.
- R2: After ctrl_en rises, panel_pwr stays low until SETTLE_TICKS (default 20) cycles with ms_tick high have been sampled. A tick sampled in the cycle that start_req is accepted does not count. panel_pwr is never high while ctrl_en is low.
- R3: In the on state, a stop_req sampled high makes panel_pwr low on the next cycle while ctrl_en stays high. ctrl_en is cleared only after SETTLE_TICKS further ticks and the handshake step.
- R4: A stop_req in the idle-off state has no effect: ctrl_en, panel_pwr and busy stay low.
- R5: With USE_HOOK=1, hook_req goes high once the settling window ends in either direction. The final transition takes place on the cycle after hook_ack is sampled high while hook_req is high. hook_ack is ignored at all other times.
- R6: busy is high exactly while a transition is in progress, which is during the settling window and the handshake step. It is low when fully off or fully on. hook_req is only high while busy is high.
- R7: start_req and stop_req are ignored while busy is high. start_req is also ignored in the on state.
- R8: After reset (rst_n low, asynchronous) ctrl_en, panel_pwr, busy and hook_req are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to power the panel up |
| stop_req | input | 1 | Request to power the panel down |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| hook_ack | input | 1 | Completion of the board-specific step |
| hook_req | output | 1 | Board-specific step is requested |
| ctrl_en | output | 1 | Enable to the display timing controller |
| panel_pwr | output | 1 | Panel power switch |
| busy | output | 1 | A transition is in progress |

## Verification
A state register that holds a wrong value shows up on the four outputs in the very next cycle, because every output is decoded directly from that register. A settling counter that is off by one shows as panel_pwr or hook_req moving one tick period early or late. The bench checks the outputs on every cycle against a behavioural model, so such an error is caught at the first cycle where it differs. A request that should be dropped but is taken shows as busy or ctrl_en changing on the following cycle.

// File: rtl/pps_pkg.sv
package pps_pkg;
    typedef enum logic [2:0] {
        PS_OFF       = 3'd0,
        PS_UP_SETTLE = 3'd1,
        PS_UP_HOOK   = 3'd2,
        PS_ON        = 3'd3,
        PS_DN_SETTLE = 3'd4,
        PS_DN_HOOK   = 3'd5
    } pps_state_e;

    typedef struct packed {
        pps_state_e st;
    } pps_fsm_regs_t;
endpackage

// File: rtl/pps_timer.sv
module pps_timer #(
    parameter int TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic done
);
    localparam int CNT_W = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_regs_t;

    timer_regs_t r_q, r_d;

    assign done = !clr && tick && (r_q.cnt == LAST);

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.cnt = '0;
        end else if (tick) begin
            if (r_q.cnt == LAST) r_d.cnt = '0;
            else                 r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
    import pps_pkg::*;
#(
    parameter bit USE_HOOK = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic       settle_done,
    input  logic       ack,
    output pps_state_e state
);
    localparam pps_state_e UP_NEXT = USE_HOOK ? PS_UP_HOOK : PS_ON;
    localparam pps_state_e DN_NEXT = USE_HOOK ? PS_DN_HOOK : PS_OFF;

    pps_fsm_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            PS_OFF:       if (start_req)   r_d.st = PS_UP_SETTLE;
            PS_UP_SETTLE: if (settle_done) r_d.st = UP_NEXT;
            PS_UP_HOOK:   if (ack)         r_d.st = PS_ON;
            PS_ON:        if (stop_req)    r_d.st = PS_DN_SETTLE;
            PS_DN_SETTLE: if (settle_done) r_d.st = DN_NEXT;
            PS_DN_HOOK:   if (ack)         r_d.st = PS_OFF;
            default:                       r_d.st = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.st <= PS_OFF;
        else        r_q    <= r_d;
    end

    assign state = r_q.st;
endmodule

// File: rtl/pps_outdec.sv
module pps_outdec
    import pps_pkg::*;
(
    input  pps_state_e state,
    output logic       ctrl_en,
    output logic       panel_pwr,
    output logic       busy,
    output logic       hook_req,
    output logic       timer_clr
);
    always_comb begin
        ctrl_en   = (state != PS_OFF);
        panel_pwr = (state == PS_ON);
        hook_req  = (state == PS_UP_HOOK) || (state == PS_DN_HOOK);
        timer_clr = !((state == PS_UP_SETTLE) || (state == PS_DN_SETTLE));
        busy      = ctrl_en && !panel_pwr;
    end
endmodule

// File: rtl/pps_top.sv
module pps_top
    import pps_pkg::*;
#(
    parameter int SETTLE_TICKS = 20,
    parameter bit USE_HOOK     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic stop_req,
    input  logic ms_tick,
    input  logic hook_ack,
    output logic hook_req,
    output logic ctrl_en,
    output logic panel_pwr,
    output logic busy
);
    pps_state_e state;
    logic       settle_done;
    logic       timer_clr;
    logic       ack_eff;
    logic       hook_req_raw;

    generate
        if (USE_HOOK) begin : g_hook
            assign ack_eff  = hook_ack;
            assign hook_req = hook_req_raw;
        end else begin : g_nohook
            assign ack_eff  = 1'b0;
            assign hook_req = 1'b0;
        end
    endgenerate

    pps_timer #(.TICKS(SETTLE_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .tick  (ms_tick),
        .done  (settle_done)
    );

    pps_fsm #(.USE_HOOK(USE_HOOK)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_req   (start_req),
        .stop_req    (stop_req),
        .settle_done (settle_done),
        .ack         (ack_eff),
        .state       (state)
    );

    pps_outdec u_dec (
        .state     (state),
        .ctrl_en   (ctrl_en),
        .panel_pwr (panel_pwr),
        .busy      (busy),
        .hook_req  (hook_req_raw),
        .timer_clr (timer_clr)
    );
endmodule

// File: rtl/pps_chk.sv
module pps_chk #(
    parameter bit USE_HOOK = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic start_req,
    input logic stop_req,
    input logic hook_ack,
    input logic hook_req,
    input logic ctrl_en,
    input logic panel_pwr,
    input logic busy
);
    // R1
    start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && start_req) |=> (ctrl_en && !panel_pwr && busy));

    // R2
    pwr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        panel_pwr |-> ctrl_en);

    // R3
    stop_drops_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (panel_pwr && stop_req) |=> (!panel_pwr && ctrl_en && busy));

    // R4
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !start_req) |=> (!ctrl_en && !busy));

    // R5
    pwr_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panel_pwr) |-> (!USE_HOOK || $past(hook_req && hook_ack)));

    // R6
    hook_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hook_req |-> busy);

    // R7
    busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !panel_pwr && ctrl_en && !hook_req) |=> ctrl_en);
endmodule

bind pps_top pps_chk #(.USE_HOOK(USE_HOOK)) u_pps_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .stop_req  (stop_req),
    .hook_ack  (hook_ack),
    .hook_req  (hook_req),
    .ctrl_en   (ctrl_en),
    .panel_pwr (panel_pwr),
    .busy      (busy)
);

// File: tb/tb_pps_top.sv
module tb_pps_top;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0, stop_req = 1'b0, ms_tick = 1'b0, hook_ack = 1'b0;
    logic hook_req, ctrl_en, panel_pwr, busy;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    // behavioural model: phase 0 off, 1 up-wait, 2 up-hook, 3 on, 4 down-wait, 5 down-hook
    int m_phase = 0;
    int m_ticks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pps_top dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .ms_tick(ms_tick), .hook_ack(hook_ack), .hook_req(hook_req),
        .ctrl_en(ctrl_en), .panel_pwr(panel_pwr), .busy(busy)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0;
            m_ticks = 0;
        end else begin
            if (m_phase == 0) begin
                if (start_req) begin m_phase = 1; m_ticks = 0; end
            end else if (m_phase == 1 || m_phase == 4) begin
                if (ms_tick) m_ticks = m_ticks + 1;
                if (m_ticks == N) m_phase = m_phase + 1;
            end else if (m_phase == 2) begin
                if (hook_ack) m_phase = 3;
            end else if (m_phase == 3) begin
                if (stop_req) begin m_phase = 4; m_ticks = 0; end
            end else if (m_phase == 5) begin
                if (hook_ack) m_phase = 0;
            end
        end
    end

    task automatic cmp(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            cmp("R1/R3 ctrl_en", ctrl_en, m_phase != 0);
            cmp("R2 panel_pwr", panel_pwr, m_phase == 3);
            cmp("R6 busy", busy, m_phase == 1 || m_phase == 2 || m_phase == 4 || m_phase == 5);
            cmp("R5 hook_req", hook_req, m_phase == 2 || m_phase == 5);
        end
    end

    // millisecond tick: one pulse every third cycle
    int tick_div = 0;
    always @(negedge clk) begin
        tick_div = (tick_div == 2) ? 0 : tick_div + 1;
        ms_tick <= (tick_div == 0);
    end

    task automatic pulse_start(); start_req = 1'b1; @(negedge clk); start_req = 1'b0; endtask
    task automatic pulse_stop();  stop_req  = 1'b1; @(negedge clk); stop_req  = 1'b0; endtask

    task automatic wait_hook();
        for (int i = 0; i < 1000 && hook_req !== 1'b1; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        cmp("R8 ctrl_en", ctrl_en, 1'b0);
        cmp("R8 panel_pwr", panel_pwr, 1'b0);
        cmp("R8 busy", busy, 1'b0);
        cmp("R8 hook_req", hook_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 stop while off
        pulse_stop();
        cmp("R4 ctrl_en", ctrl_en, 1'b0);
        cmp("R4 busy", busy, 1'b0);

        // R1 start
        pulse_start();
        cmp("R1 ctrl_en", ctrl_en, 1'b1);
        cmp("R1 panel_pwr", panel_pwr, 1'b0);

        // R7 requests during the wait; R5 ack outside hook ignored
        repeat (4) @(negedge clk);
        pulse_stop();
        pulse_start();
        hook_ack = 1'b1; @(negedge clk); hook_ack = 1'b0;
        cmp("R7 ctrl_en", ctrl_en, 1'b1);
        cmp("R5 panel_pwr", panel_pwr, 1'b0);

        wait_hook();
        cmp("R5 hook_req", hook_req, 1'b1);
        repeat (5) @(negedge clk);
        cmp("R5 stall pwr", panel_pwr, 1'b0);
        hook_ack = 1'b1; @(negedge clk); hook_ack = 1'b0;
        cmp("R5 pwr after ack", panel_pwr, 1'b1);

        // R7 start in on state ignored
        pulse_start();
        cmp("R7 busy in on", busy, 1'b0);

        // R3 power-down
        repeat (3) @(negedge clk);
        pulse_stop();
        cmp("R3 panel_pwr", panel_pwr, 1'b0);
        cmp("R3 ctrl_en", ctrl_en, 1'b1);
        wait_hook();
        cmp("R3 ctrl_en before ack", ctrl_en, 1'b1);
        hook_ack = 1'b1; @(negedge clk); hook_ack = 1'b0;
        cmp("R3 ctrl_en cleared", ctrl_en, 1'b0);

        // second cycle with ack held high ahead of the hook step
        @(negedge clk);
        hook_ack = 1'b1;
        pulse_start();
        repeat (200) @(negedge clk);
        cmp("R2 on with held ack", panel_pwr, 1'b1);
        stop_req = 1'b1; start_req = 1'b1; @(negedge clk);
        stop_req = 1'b0; start_req = 1'b0;
        repeat (200) @(negedge clk);
        cmp("R3 off with held ack", ctrl_en, 1'b0);
        hook_ack = 1'b0;
        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule